// File: doc/BRIEF.md
# Bit-Clock-Locked Matching Clock Divider

This block generates the clock for a converter's dynamic element matching stage by dividing the serial audio bit clock instead of relying on a free-running oscillator. Because the matching clock is an exact sub-multiple of the bit clock, the two frequencies cannot beat against each other inside the converter. All logic runs on the falling edge of the bit clock. The output therefore only ever moves half a bit period away from the rising edge on which the converter latches a new sample.

A two-bit ratio code selects a divide factor of 4, 8 or 16. With a 2.8224 MHz bit clock, these give 705.6, 352.8 or 176.4 kHz. A fourth code parks the output low. When word select falls, the block marks the start of a frame. At that point it restarts its divider and loads a newly requested ratio, so the output phase is fixed relative to the frame and ratio changes never produce a runt pulse. A parameter can instead select a free-running variant that loads the ratio at the end of each output period.

Top module: `dem_clk_gen`

## Requirements
- R1: While `rst_n` is low at a falling bit-clock edge, `dem_clk` is low after that edge, and the held ratio becomes the park code 11. After reset, `dem_clk` stays low until the first frame start.
- R2: `dem_clk` changes value only at a falling edge of `bck`, and never at a rising edge.
- R3: With ratio code 00 held at frame start, `dem_clk` is two bit periods low and then two high, for a period of 4 bit clocks.
- R4: With ratio code 01, `dem_clk` has a period of 8 bit clocks at 50% duty.
- R5: With ratio code 10, `dem_clk` has a period of 16 bit clocks at 50% duty.
- R6: With ratio code 11 held, `dem_clk` stays low.
- R7: A frame start is a falling bit-clock edge at which `ws` is sampled low and was sampled high at the previous falling edge. After a frame start, `dem_clk` is low and the divider restarts from zero. Its first rise comes half a period (2, 4 or 8 falling edges) later, whatever the phase was before.
- R8: `ratio_sel` is sampled only at a frame start. A change between frame starts has no effect on `dem_clk` until the next frame start.
- R9: When frames are a multiple of 16 bit clocks long, switching the ratio at a frame start produces no pulse shorter than half of either period. The output is low at the frame start and follows the new ratio from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Serial bit clock; the whole block runs on its falling edge |
| rst_n | input | 1 | Active-low synchronous reset, sampled on the falling edge of `bck` |
| ws | input | 1 | Word select; its falling edge marks the start of a frame |
| ratio_sel | input | 2 | Ratio code: 00 /4, 01 /8, 10 /16, 11 output held low |
| dem_clk | output | 1 | Registered matching clock |

## Verification
The in-line assertions check on every falling edge that the divide counter stays below its half-period terminal count and that the output holds still whenever the counter is mid-count. They also check that the held ratio moves only on a load strobe, that the park code keeps the output low, and that a frame start leaves the output low with the counter cleared. Only the bench scenarios can show the actual output periods for each code, the rephasing after a short frame, the deferral of a mid-frame ratio change, and that no output edge ever falls at a rising bit-clock edge. They do this by comparing every bit period against a model built from frame position and ratio code.

// File: rtl/dem_clk_pkg.sv
package dem_clk_pkg;

   typedef enum logic [1:0] {
      RATIO_SLOW0 = 2'b00,
      RATIO_SLOW1 = 2'b01,
      RATIO_SLOW2 = 2'b10,
      RATIO_PARK  = 2'b11
   } ratio_e;

   // terminal count of the half-period counter for a given code
   function automatic int half_term(input logic [1:0] code, input int min_log2);
      return (1 << (min_log2 - 1 + int'(code))) - 1;
   endfunction

endpackage

// File: rtl/ws_frame_detect.sv
module ws_frame_detect #(
   parameter bit FRAME_ALIGN = 1'b1
) (
   input  logic bck,
   input  logic rst_n,
   input  logic ws,
   output logic frame_start
);

   logic ws_q;

   always_ff @(negedge bck) begin
      if (!rst_n) ws_q <= 1'b0;
      else        ws_q <= ws;
   end

   generate
      if (FRAME_ALIGN) begin : g_align
         assign frame_start = ws_q & ~ws;
      end else begin : g_free
         assign frame_start = 1'b0;
      end
   endgenerate

   // R7
   start_on_low_ws_chk: assert property (@(negedge bck) disable iff (!rst_n)
      frame_start |-> (ws == 1'b0));

endmodule

// File: rtl/ratio_hold.sv
module ratio_hold
   import dem_clk_pkg::*;
(
   input  logic       bck,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] sel,
   output ratio_e     code
);

   ratio_e code_q;

   always_ff @(negedge bck) begin
      if (!rst_n)    code_q <= RATIO_PARK;
      else if (load) code_q <= ratio_e'(sel);
   end

   assign code = code_q;

   // R8
   code_steady_chk: assert property (@(negedge bck) disable iff (!rst_n)
      !load |=> $stable(code_q));

endmodule

// File: rtl/dem_divider.sv
module dem_divider
   import dem_clk_pkg::*;
#(
   parameter int MIN_DIV_LOG2 = 2
) (
   input  logic   bck,
   input  logic   rst_n,
   input  logic   restart,
   input  ratio_e code,
   output logic   dem,
   output logic   period_end
);

   localparam int CNT_W = MIN_DIV_LOG2 + 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             dem_q;

   initial begin
      assert (MIN_DIV_LOG2 >= 1 && MIN_DIV_LOG2 <= 12)
         else $error("dem_divider: MIN_DIV_LOG2 out of range");
   end

   always_comb term = CNT_W'(half_term(code, MIN_DIV_LOG2));

   always_ff @(negedge bck) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dem_q <= 1'b0;
      end else if (restart || code == RATIO_PARK) begin
         cnt_q <= '0;
         dem_q <= 1'b0;
      end else if (cnt_q == term) begin
         cnt_q <= '0;
         dem_q <= ~dem_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // end of a full output period: the high half is about to close
   assign period_end = (code == RATIO_PARK) || ((cnt_q == term) && dem_q);
   assign dem        = dem_q;

   // R3 R4 R5
   cnt_below_term_chk: assert property (@(negedge bck) disable iff (!rst_n)
      cnt_q <= CNT_W'(half_term(RATIO_SLOW2, MIN_DIV_LOG2)));

   // R3 R4 R5
   mid_count_quiet_chk: assert property (@(negedge bck) disable iff (!rst_n)
      (cnt_q != '0) |-> $stable(dem_q));

   // R6
   park_low_chk: assert property (@(negedge bck) disable iff (!rst_n)
      (code == RATIO_PARK) |-> !dem_q);

   // R7
   restart_low_chk: assert property (@(negedge bck) disable iff (!rst_n)
      restart |=> (!dem_q && cnt_q == '0));

endmodule

// File: rtl/dem_clk_gen.sv
module dem_clk_gen
   import dem_clk_pkg::*;
#(
   parameter int MIN_DIV_LOG2 = 2,
   parameter bit FRAME_ALIGN  = 1'b1
) (
   input  logic       bck,
   input  logic       rst_n,
   input  logic       ws,
   input  logic [1:0] ratio_sel,
   output logic       dem_clk
);

   logic   frame_start;
   logic   period_end;
   logic   load;
   ratio_e code;

   ws_frame_detect #(.FRAME_ALIGN(FRAME_ALIGN)) u_frame (
      .bck         (bck),
      .rst_n       (rst_n),
      .ws          (ws),
      .frame_start (frame_start)
   );

   generate
      if (FRAME_ALIGN) begin : g_load_frame
         assign load = frame_start;
      end else begin : g_load_period
         assign load = period_end;
      end
   endgenerate

   ratio_hold u_ratio (
      .bck   (bck),
      .rst_n (rst_n),
      .load  (load),
      .sel   (ratio_sel),
      .code  (code)
   );

   dem_divider #(.MIN_DIV_LOG2(MIN_DIV_LOG2)) u_div (
      .bck        (bck),
      .rst_n      (rst_n),
      .restart    (frame_start),
      .code       (code),
      .dem        (dem_clk),
      .period_end (period_end)
   );

   // R1
   reset_low_chk: assert property (@(negedge bck)
      !rst_n |=> !dem_clk);

endmodule

// File: tb/dem_clk_gen_tb.sv
module dem_clk_gen_tb;

   logic       bck = 1'b0;
   logic       rst_n = 1'b0;
   logic       ws = 1'b1;
   logic [1:0] ratio_sel = 2'b00;
   logic       dem_clk;

   int n_checks = 0;
   int n_fail   = 0;
   int edge_cnt = 0;
   int edge_bad = 0;
   bit done     = 1'b0;

   logic  exp_q[$];
   string tag_q[$];

   always #4 bck = ~bck;

   dem_clk_gen u_dut (
      .bck       (bck),
      .rst_n     (rst_n),
      .ws        (ws),
      .ratio_sel (ratio_sel),
      .dem_clk   (dem_clk)
   );

   // monitor: one expected value per bit period, sampled mid-period
   always @(posedge bck) begin
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (dem_clk !== e) begin
            n_fail++;
            $display("FAIL %s: dem_clk=%b expected %b at %0t", t, dem_clk, e, $time);
         end
      end
   end

   // R2: every output transition must coincide with bck low (falling edge)
   always @(dem_clk) begin
      if (rst_n) begin
         edge_cnt++;
         if (bck !== 1'b0) edge_bad++;
      end
   end

   function automatic logic model(input logic [1:0] code, input int j);
      int half;
      if (code == 2'b11) return 1'b0;
      half = 2 << code;
      return logic'((j / half) % 2);
   endfunction

   task automatic push(input logic e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic step(input logic ws_v, input logic [1:0] rs, input logic e, input string t);
      @(posedge bck);
      ws        = ws_v;
      ratio_sel = rs;
      @(negedge bck);
      #1;
      push(e, t);
   endtask

   task automatic frame(input logic [1:0] code, input int nbits, input int chg_at,
                        input logic [1:0] chg_code, input string t);
      for (int j = 0; j < nbits; j++) begin
         logic [1:0] rs;
         string      tt;
         rs = (j >= chg_at) ? chg_code : code;
         tt = (j == 0) ? "R9 frame start low" : t;
         step((j < nbits / 2) ? 1'b0 : 1'b1, rs, model(code, j), tt);
      end
   endtask

   initial begin
      // R1: reset holds output low
      repeat (3) step(1'b1, 2'b00, 1'b0, "R1 in reset");
      @(posedge bck);
      rst_n = 1'b1;
      @(negedge bck);
      #1;
      push(1'b0, "R1 after release");
      // park code from reset holds until a frame start, despite ratio_sel=00 (R8)
      repeat (6) step(1'b1, 2'b00, 1'b0, "R8 no frame yet");

      frame(2'b00, 64, 64, 2'b00, "R3 div4");
      frame(2'b00, 64, 64, 2'b00, "R3 div4 steady");
      frame(2'b01, 64, 64, 2'b01, "R4 div8");
      frame(2'b10, 64, 64, 2'b10, "R5 div16");
      frame(2'b10, 64, 20, 2'b00, "R8 mid-frame change ignored");
      frame(2'b00, 64, 64, 2'b00, "R9 new ratio at frame");
      frame(2'b11, 64, 64, 2'b11, "R6 park");
      frame(2'b10, 40, 40, 2'b10, "R7 short frame");
      frame(2'b10, 64, 64, 2'b10, "R7 rephase after short frame");
      frame(2'b01, 64, 30, 2'b11, "R8 park request deferred");
      frame(2'b00, 32, 32, 2'b00, "R3 div4 short frame");

      @(posedge bck);
      @(posedge bck);

      n_checks++;
      if (edge_bad != 0 || edge_cnt == 0) begin
         n_fail++;
         $display("FAIL R2: %0d of %0d output edges off a falling bck edge, expected 0 (edges>0)",
                  edge_bad, edge_cnt);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule